// File: doc/BRIEF.md
# SDRAM Write Burst Terminator

This block sits on the controller side of an SDRAM interface. It issues exactly one write burst into a row that is already open, and then closes that row with a precharge to the same bank. A request carries a bank, a column, the burst's data words packed into one vector, and a truncate count. The count sets how the burst ends. A count of 1, 2 or 3 cuts the burst short: that many beats are written, and the precharge follows in the very next clock. Any other value lets all four beats land. The block then waits one recovery clock before it precharges.

A cut is handled with care because the precharge stops the write with zero data latency. Whatever sits on the data pins in the precharge cycle would otherwise be written. The block therefore drives the byte mask high and releases the data pins in that cycle. On a full burst the mask stays low and the precharge comes only after the recovery clock. A busy flag blocks new requests while a burst is in progress. A one-cycle done pulse marks the clock that follows the precharge. Row activation, refresh, reads and scheduling across banks belong to other blocks.

The sequencer has five states:
- `ST_IDLE` waits for a request.
- `ST_ISSUE` puts the write command and beat 0 on the pins.
- `ST_STREAM` drives the following beats.
- `ST_RECOVER` is the quiet clock after the last beat of a full burst.
- `ST_CLOSE` issues the precharge.

The transitions are as follows:
- IDLE goes to ISSUE when a request is accepted.
- ISSUE or STREAM goes to STREAM while beats remain.
- ISSUE or STREAM goes to CLOSE after the last beat of a cut burst.
- ISSUE or STREAM goes to RECOVER after the last beat of a full burst.
- RECOVER always goes to CLOSE.
- CLOSE always goes to IDLE.

Top module: `sdram_wr_term`

## Requirements
- R1: While reset is asserted and after it ends, with no request pending, `busy`, `done`, `wdata_oe` and `wmask` are low and `sd_cmd` is NOP.
- R2: `sd_cmd` encodes {chip select, row strobe, column strobe, write enable}, all active low: WRITE = 0100, PRECHARGE = 0010, NOP = 0111. A request seen with `req_valid` high while `busy` is low is accepted at that clock edge. In the next cycle the outputs show WRITE, the request's bank on `sd_bank`, the column in the low bits of `sd_addr`, beat 0 (`req_data[15:0]`) on `wdata` with `wdata_oe` high, and `wmask` low.
- R3: Beat k (`req_data[16k+15:16k]`) is driven in the k-th cycle after the WRITE cycle. During these cycles `wdata_oe` is high, `wmask` is low and the command is NOP.
- R4: A truncate count n of 1 to 3 writes beats 0 to n-1. In the next cycle the outputs show PRECHARGE, `wmask` all ones and `wdata_oe` low.
- R5: A truncate count of 0 or 4 to 7 writes all four beats. One NOP cycle then follows with `wdata_oe` and `wmask` low, and after it comes PRECHARGE with `wmask` low.
- R6: The PRECHARGE command carries the bank of the WRITE. `sd_addr` bit 10 is low, so only that bank closes. `sd_addr` is zero in every non-WRITE cycle, and `sd_bank` does not change while `busy` is high.
- R7: `busy` is high from the WRITE cycle through the PRECHARGE cycle. A request presented while `busy` is high is ignored and changes no later output.
- R8: `done` is high for exactly the one cycle after PRECHARGE, and `busy` is low in that cycle. A request presented in that cycle is accepted, so bursts can run back to back.
- R9: `wdata_oe` is low in every cycle that carries no valid beat: idle, recovery and precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request strobe |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Start column |
| req_data | input | BURST_LEN*DATA_W | Burst words, beat k in slice k |
| req_trunc | input | BEAT_W+1 | Truncate count (1..BURST_LEN-1 cuts the burst) |
| busy | output | 1 | Burst in progress, requests blocked |
| done | output | 1 | One-cycle pulse after the precharge |
| sd_cmd | output | 4 | {cs, ras, cas, we}, active low |
| sd_bank | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Address bus (column on WRITE, bit 10 low) |
| wdata | output | DATA_W | Write data toward the DQ pins |
| wdata_oe | output | 1 | DQ output enable |
| wmask | output | DATA_W/8 | DQ byte mask, high blocks the write |

## Verification
The assertions check every clock for the following pin-level relationships:
- A masked precharge directly follows a driven beat.
- An unmasked precharge comes two clocks after the last beat, with a quiet clock between them.
- Bit 10 is low on WRITE and PRECHARGE, and the bank holds steady while busy.
- Done follows a precharge, and the pins are quiet while idle.

Only the scoreboard scenarios can show the rest:
- The exact beat data, including the order of the words.
- That each truncate count cuts after the right number of beats.
- That requests arriving mid-burst leave no trace.
- That a request arriving on the done cycle starts a new burst at once.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_STREAM,
        ST_RECOVER,
        ST_CLOSE
    } wr_state_t;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP   = 4'b0111;
    localparam logic [3:0] CMD_WRITE = 4'b0100;
    localparam logic [3:0] CMD_PRE   = 4'b0010;

endpackage

// File: rtl/wr_term_fsm.sv
module wr_term_fsm
    import sdram_wr_pkg::*;
#(
    parameter int BURST_LEN = 4,
    localparam int BEAT_W   = $clog2(BURST_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              cut,
    input  logic [BEAT_W-1:0] last_idx,
    output logic              accept,
    output logic [BEAT_W-1:0] beat_idx,
    output logic [3:0]        cmd,
    output logic              drive_col,
    output logic              oe,
    output logic              mask,
    output logic              busy,
    output logic              done
);

    wr_state_t         state, state_nx;
    logic [BEAT_W-1:0] idx_q, idx_nx;
    logic              done_q;

    assign accept   = (state == ST_IDLE) && req_valid;
    assign beat_idx = idx_q;
    assign done     = done_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            state  <= state_nx;
            idx_q  <= idx_nx;
            done_q <= (state == ST_CLOSE);
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        idx_nx   = idx_q;
        unique case (state)
            ST_IDLE: begin
                idx_nx = '0;
                if (req_valid) state_nx = ST_ISSUE;
            end
            ST_ISSUE, ST_STREAM: begin
                if (idx_q == last_idx) begin
                    state_nx = cut ? ST_CLOSE : ST_RECOVER;
                end else begin
                    state_nx = ST_STREAM;
                    idx_nx   = idx_q + 1'b1;
                end
            end
            ST_RECOVER: state_nx = ST_CLOSE;
            ST_CLOSE:   state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd       = CMD_NOP;
        drive_col = 1'b0;
        oe        = 1'b0;
        mask      = 1'b0;
        busy      = 1'b1;
        unique case (state)
            ST_IDLE:    busy = 1'b0;
            ST_ISSUE: begin
                cmd       = CMD_WRITE;
                drive_col = 1'b1;
                oe        = 1'b1;
            end
            ST_STREAM:  oe = 1'b1;
            ST_RECOVER: ;
            ST_CLOSE: begin
                cmd  = CMD_PRE;
                mask = cut;
            end
            default:    busy = 1'b0;
        endcase
    end

    // R7: a write command is never repeated within one burst
    assert_single_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISSUE) |=> (state != ST_ISSUE));

    // R8: done only after the close state
    assert_done_after_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state == ST_IDLE));

endmodule

// File: rtl/wr_term_datapath.sv
module wr_term_datapath #(
    parameter int DATA_W    = 16,
    parameter int BANK_W    = 2,
    parameter int COL_W     = 8,
    parameter int ADDR_W    = 11,
    parameter int BURST_LEN = 4,
    localparam int BEAT_W   = $clog2(BURST_LEN),
    localparam int TRUNC_W  = BEAT_W + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          accept,
    input  logic [BANK_W-1:0]             req_bank,
    input  logic [COL_W-1:0]              req_col,
    input  logic [BURST_LEN*DATA_W-1:0]   req_data,
    input  logic [TRUNC_W-1:0]            req_trunc,
    input  logic [BEAT_W-1:0]             beat_idx,
    input  logic                          oe,
    input  logic                          drive_col,
    output logic [BEAT_W-1:0]             last_idx,
    output logic                          cut,
    output logic [BANK_W-1:0]             sd_bank,
    output logic [ADDR_W-1:0]             sd_addr,
    output logic [DATA_W-1:0]             wdata
);

    localparam logic [TRUNC_W-1:0] FULL_CNT = TRUNC_W'(BURST_LEN);
    localparam logic [BEAT_W-1:0]  LAST_FULL = BEAT_W'(BURST_LEN - 1);

    logic [BANK_W-1:0]           bank_q;
    logic [COL_W-1:0]            col_q;
    logic [BURST_LEN*DATA_W-1:0] data_q;
    logic [BEAT_W-1:0]           last_q;
    logic                        cut_q;
    logic                        cut_in;
    logic [TRUNC_W-1:0]          trunc_m1;
    logic [DATA_W-1:0]           words [BURST_LEN];

    assign cut_in   = (req_trunc != '0) && (req_trunc < FULL_CNT);
    assign trunc_m1 = req_trunc - 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
            col_q  <= '0;
            data_q <= '0;
            last_q <= LAST_FULL;
            cut_q  <= 1'b0;
        end else if (accept) begin
            bank_q <= req_bank;
            col_q  <= req_col;
            data_q <= req_data;
            cut_q  <= cut_in;
            last_q <= cut_in ? trunc_m1[BEAT_W-1:0] : LAST_FULL;
        end
    end

    for (genvar g = 0; g < BURST_LEN; g++) begin : g_word
        assign words[g] = data_q[g*DATA_W +: DATA_W];
    end

    always_comb begin
        sd_addr = '0;
        if (drive_col) sd_addr[COL_W-1:0] = col_q;
    end

    assign wdata    = oe ? words[beat_idx] : '0;
    assign sd_bank  = bank_q;
    assign last_idx = last_q;
    assign cut      = cut_q;

endmodule

// File: rtl/sdram_wr_term.sv
module sdram_wr_term
    import sdram_wr_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int BANK_W    = 2,
    parameter int COL_W     = 8,
    parameter int ADDR_W    = 11,
    parameter int AP_BIT    = 10,
    parameter int BURST_LEN = 4,
    localparam int BEAT_W   = $clog2(BURST_LEN),
    localparam int TRUNC_W  = BEAT_W + 1,
    localparam int MASK_W   = DATA_W / 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [BANK_W-1:0]           req_bank,
    input  logic [COL_W-1:0]            req_col,
    input  logic [BURST_LEN*DATA_W-1:0] req_data,
    input  logic [TRUNC_W-1:0]          req_trunc,
    output logic                        busy,
    output logic                        done,
    output logic [3:0]                  sd_cmd,
    output logic [BANK_W-1:0]           sd_bank,
    output logic [ADDR_W-1:0]           sd_addr,
    output logic [DATA_W-1:0]           wdata,
    output logic                        wdata_oe,
    output logic [MASK_W-1:0]           wmask
);

    logic              accept;
    logic              cut;
    logic [BEAT_W-1:0] last_idx;
    logic [BEAT_W-1:0] beat_idx;
    logic              drive_col;
    logic              mask_one;

    wr_term_fsm #(.BURST_LEN(BURST_LEN)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .cut       (cut),
        .last_idx  (last_idx),
        .accept    (accept),
        .beat_idx  (beat_idx),
        .cmd       (sd_cmd),
        .drive_col (drive_col),
        .oe        (wdata_oe),
        .mask      (mask_one),
        .busy      (busy),
        .done      (done)
    );

    wr_term_datapath #(
        .DATA_W    (DATA_W),
        .BANK_W    (BANK_W),
        .COL_W     (COL_W),
        .ADDR_W    (ADDR_W),
        .BURST_LEN (BURST_LEN)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_bank  (req_bank),
        .req_col   (req_col),
        .req_data  (req_data),
        .req_trunc (req_trunc),
        .beat_idx  (beat_idx),
        .oe        (wdata_oe),
        .drive_col (drive_col),
        .last_idx  (last_idx),
        .cut       (cut),
        .sd_bank   (sd_bank),
        .sd_addr   (sd_addr),
        .wdata     (wdata)
    );

    assign wmask = {MASK_W{mask_one}};

    // R2: the write command always carries a live, unmasked beat
    assert_write_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_WRITE) |-> (wdata_oe && (wmask == '0)));

    // R4: a masked precharge directly follows a driven beat, pins released
    assert_cut_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((sd_cmd == CMD_PRE) && (wmask != '0)) |-> (!wdata_oe && $past(wdata_oe)));

    // R5: an unmasked precharge comes after one quiet recovery clock
    assert_full_recovery_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((sd_cmd == CMD_PRE) && (wmask == '0)) |-> (!$past(wdata_oe) && $past(wdata_oe, 2)));

    // R6: bit 10 stays low, so only the addressed bank is affected
    assert_single_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((sd_cmd == CMD_WRITE) || (sd_cmd == CMD_PRE)) |-> !sd_addr[AP_BIT]);

    // R6: bank holds for the whole burst
    assert_bank_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(sd_bank));

    // R8: done follows a precharge and busy has dropped
    assert_done_after_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (($past(sd_cmd) == CMD_PRE) && !busy));

    // R9: the pins are quiet while idle
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ((sd_cmd == CMD_NOP) && !wdata_oe));

endmodule

// File: tb/sdram_wr_term_test.sv
module sdram_wr_term_test;

    localparam int DW = 16;
    localparam int BW = 2;
    localparam int CW = 8;
    localparam int AW = 11;
    localparam int BL = 4;
    localparam int TW = 3;
    localparam int MW = DW / 8;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic              req_valid;
    logic [BW-1:0]     req_bank;
    logic [CW-1:0]     req_col;
    logic [BL*DW-1:0]  req_data;
    logic [TW-1:0]     req_trunc;
    logic              busy, done, wdata_oe;
    logic [3:0]        sd_cmd;
    logic [BW-1:0]     sd_bank;
    logic [AW-1:0]     sd_addr;
    logic [DW-1:0]     wdata;
    logic [MW-1:0]     wmask;

    sdram_wr_term uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
        .req_col(req_col), .req_data(req_data), .req_trunc(req_trunc),
        .busy(busy), .done(done), .sd_cmd(sd_cmd), .sd_bank(sd_bank),
        .sd_addr(sd_addr), .wdata(wdata), .wdata_oe(wdata_oe), .wmask(wmask)
    );

    typedef struct {
        logic [3:0]    cmd;
        logic [BW-1:0] ba;
        logic [AW-1:0] addr;
        logic          oe;
        logic [DW-1:0] dq;
        logic [MW-1:0] mask;
        logic          busy;
        logic          done;
        string         tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops one expected item per cycle, or checks idle pins
    initial begin
        wait (rst_n === 1'b1);
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "cmd",  64'(sd_cmd),   64'(e.cmd));
                chk(e.tag, "busy", 64'(busy),     64'(e.busy));
                chk(e.tag, "done", 64'(done),     64'(e.done));
                chk(e.tag, "oe",   64'(wdata_oe), 64'(e.oe));
                chk(e.tag, "mask", 64'(wmask),    64'(e.mask));
                if (e.oe) chk(e.tag, "wdata", 64'(wdata), 64'(e.dq));
                chk("R6", "addr", 64'(sd_addr), 64'(e.addr));
                if (e.cmd == C_WR || e.cmd == C_PRE)
                    chk("R6", "bank", 64'(sd_bank), 64'(e.ba));
            end else begin
                chk("R9", "idle cmd",  64'(sd_cmd),   64'(C_NOP));
                chk("R9", "idle oe",   64'(wdata_oe), 64'(0));
                chk("R8", "idle busy", 64'(busy),     64'(0));
                chk("R8", "idle done", 64'(done),     64'(0));
            end
        end
    end

    task automatic push(logic [3:0] c, logic [BW-1:0] ba, logic [AW-1:0] a, logic oe,
                        logic [DW-1:0] d, logic [MW-1:0] m, logic b, logic dn, string t);
        exp_t e;
        e.cmd = c; e.ba = ba; e.addr = a; e.oe = oe; e.dq = d;
        e.mask = m; e.busy = b; e.done = dn; e.tag = t;
        q.push_back(e);
    endtask

    // driver: waits for an empty scoreboard, drives one request, predicts it
    task automatic send(logic [BW-1:0] bank, logic [CW-1:0] col,
                        logic [BL*DW-1:0] data, logic [TW-1:0] trunc, int poke);
        int lim;
        bit cutb;
        @(negedge clk);
        while (q.size() != 0) @(negedge clk);
        req_valid = 1'b1; req_bank = bank; req_col = col;
        req_data = data; req_trunc = trunc;
        cutb = (trunc >= 1) && (trunc <= BL - 1);
        lim  = cutb ? int'(trunc) : BL;
        for (int k = 0; k < lim; k++) begin
            if (k == 0)
                push(C_WR, bank, AW'(col), 1'b1, data[0 +: DW], '0, 1'b1, 1'b0,
                     poke > 0 ? "R7" : "R2");
            else
                push(C_NOP, bank, '0, 1'b1, data[k*DW +: DW], '0, 1'b1, 1'b0,
                     poke > 0 ? "R7" : "R3");
        end
        if (cutb) begin
            push(C_PRE, bank, '0, 1'b0, '0, '1, 1'b1, 1'b0, poke > 0 ? "R7" : "R4");
        end else begin
            push(C_NOP, bank, '0, 1'b0, '0, '0, 1'b1, 1'b0, poke > 0 ? "R7" : "R5");
            push(C_PRE, bank, '0, 1'b0, '0, '0, 1'b1, 1'b0, poke > 0 ? "R7" : "R5");
        end
        push(C_NOP, bank, '0, 1'b0, '0, '0, 1'b0, 1'b1, "R8");
        @(negedge clk);
        req_valid = 1'b0;
        if (poke > 0) begin
            repeat (poke - 1) @(negedge clk);
            req_valid = 1'b1; req_bank = ~bank; req_col = ~col;
            req_data = ~data; req_trunc = 3'd1;
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_bank = '0; req_col = '0;
        req_data = '0; req_trunc = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy", 64'(busy), 64'(0));
        chk("R1", "done", 64'(done), 64'(0));
        chk("R1", "cmd",  64'(sd_cmd), 64'(C_NOP));
        chk("R1", "oe",   64'(wdata_oe), 64'(0));
        chk("R1", "mask", 64'(wmask), 64'(0));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        send(2'd1, 8'h3C, 64'h4444_3333_2222_1111, 3'd0, 0);   // full, R5
        repeat (2) @(negedge clk);
        send(2'd2, 8'h10, 64'hD004_C003_B002_A001, 3'd1, 0);   // cut after 1, R4
        send(2'd3, 8'hF0, 64'h0F0F_F0F0_1234_5678, 3'd2, 0);   // cut after 2, R4
        send(2'd0, 8'h01, 64'hCAFE_BEEF_DEAD_FACE, 3'd3, 0);   // cut after 3, R4
        send(2'd1, 8'h80, 64'h8888_7777_6666_5555, 3'd4, 0);   // full, R5
        send(2'd2, 8'h55, 64'h0001_0002_0003_0004, 3'd7, 0);   // out of range is full, R5
        send(2'd3, 8'hAA, 64'h9999_AAAA_BBBB_CCCC, 3'd0, 2);   // mid-burst request ignored, R7
        send(2'd0, 8'h0F, 64'h1357_2468_ACE0_BDF1, 3'd2, 1);   // ignored during cut burst, R7
        repeat (3) @(negedge clk);
        send(2'd1, 8'h77, 64'hFFFF_0000_FFFF_0000, 3'd3, 0);
        while (q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule